// File: doc/BRIEF.md
# Interrupt Aggregator with Deferral Lock

This block gathers a set of peripheral request lines into one interrupt for the processor. Each line is watched for a rising edge; an edge latches a pending bit that stays set until software clears it. A per-line disable mask decides which pending bits reach the processor output. Software can also set or clear pending bits directly, which is useful both for testing and for raising requests from software.

A global lock bit stops delivery entirely. While it is set, new hardware edges are not written to the pending bits. They are parked in a separate deferred set, and that set is merged back into the pending bits when the lock is released. Setting the lock wipes the pending bits, so only the deferred set carries requests across a locked period. Line 0 is reserved and ignores its hardware input.

The block is reached through a single-beat register port in a 4 KB window. The window also holds seven general 32-bit words that software uses to hold handler bookkeeping: a 64-bit handler table base, a 64-bit cause, a 64-bit return address and an index.

Top module: `irq_hub`

## Requirements
- R1: After reset, every mask bit reads 1, the pending bits, the deferred set and the lock read 0, all seven general words read 0, and `cpu_irq` is 0.
- R2: A rising edge on request line k (k at least 1) sets pending bit k, which is read at offset 0x004, bit k. A line that stays high does not set its bit again after the bit is cleared. Line 0 never sets its pending bit from hardware.
- R3: A write to offset 0x008 clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R4: A write to offset 0x00C sets each pending bit whose data bit is 1, line 0 included. When a set from any source and a clear land on the same bit in the same cycle, the bit ends up set.
- R5: The mask at offset 0x000 is read/write, with one bit per line, bit k for line k. A mask bit of 1 blocks its line. `cpu_irq` is a register. It is 1 one cycle after a cycle in which the lock is 0 and some pending bit has a mask bit of 0.
- R6: The lock is bit 0 of offset 0x028. While it is 1, `cpu_irq` is 0 one cycle later, and hardware edges go to the deferred set instead of the pending bits. Writing bit 0 = 1 clears all pending bits. Writing bit 0 = 0 while locked moves the deferred set, plus any edge in that same cycle, into the pending bits, and empties the deferred set.
- R7: Offsets 0x010, 0x014, 0x018, 0x01C, 0x020, 0x024 and 0x02C are plain 32-bit read/write words.
- R8: Mask and pending bits at N and above, and lock bits 31:1, read 0. Reads of 0x008, 0x00C, undefined offsets and misaligned addresses (address bits 1:0 not zero) return 0. Writes to undefined or misaligned offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_LINES | Peripheral request lines, bit 0 unused |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while a read is presented |
| cpu_irq | output | 1 | Registered interrupt to the processor |

## Verification
Two timing cases are the hardest to reach from the ports. One is a hardware edge that arrives in the same cycle as the write that releases the lock. The other is an edge that coincides with a clear of its own bit. Both need the request line and the register write to line up on one clock edge. The bench drives request lines and register accesses from the same step task, so one step can carry an edge and a write together. Directed steps build both cases on purpose. A long seeded random run, in which lines toggle freely while lock, clear, raise and mask writes are mixed in, produces many more such overlaps, and each one is checked against a model that advances one cycle at a time.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int BUS_DW        = 32;
    localparam int BUS_AW        = 12;
    localparam int WORD_AW       = BUS_AW - 2;
    localparam int SCRATCH_SLOTS = 7;
    localparam int SLOT_W        = $clog2(SCRATCH_SLOTS);

    // Word index (byte offset / 4) of every register in the window
    typedef enum logic [WORD_AW-1:0] {
        W_MASK   = 10'd0,
        W_PEND   = 10'd1,
        W_CLR    = 10'd2,
        W_RAISE  = 10'd3,
        W_TBL_LO = 10'd4,
        W_TBL_HI = 10'd5,
        W_CAU_LO = 10'd6,
        W_CAU_HI = 10'd7,
        W_RET_LO = 10'd8,
        W_RET_HI = 10'd9,
        W_LOCK   = 10'd10,
        W_INDEX  = 10'd11
    } reg_word_e;

    typedef struct packed {
        logic              sel;
        logic              wr;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              mask_we;
        logic              clr_we;
        logic              raise_we;
        logic              lock_we;
        logic              scratch_we;
        logic              scratch_hit;
        logic [SLOT_W-1:0] slot;
    } bus_dec_t;

    function automatic logic is_scratch(input logic [WORD_AW-1:0] w);
        return (w >= W_TBL_LO && w <= W_RET_HI) || (w == W_INDEX);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [WORD_AW-1:0] w);
        logic [WORD_AW-1:0] rel;
        rel = w - W_TBL_LO;
        if (w == W_INDEX) return SLOT_W'(SCRATCH_SLOTS - 1);
        return rel[SLOT_W-1:0];
    endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int          N           = 6,
    parameter logic [N-1:0] ACTIVE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign rise_o[i] = ACTIVE_MASK[i] & req_i[i] & ~req_q[i];
    end
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rise_i,
    input  logic         mask_we_i,
    input  logic         clr_we_i,
    input  logic         raise_we_i,
    input  logic         lock_we_i,
    input  logic [N-1:0] wbits_i,
    input  logic         lock_bit_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] defer_o,
    output logic         lock_o,
    output logic         irq_o
);
    logic [N-1:0] pend_q, mask_q, defer_q;
    logic         lock_q, irq_q;
    logic [N-1:0] clr_v, set_v, defer_d;
    logic         release_now, lock_now;

    always_comb begin
        release_now = lock_we_i & ~lock_bit_i & lock_q;
        lock_now    = lock_we_i & lock_bit_i;
        clr_v = '0;
        set_v = '0;
        if (clr_we_i)   clr_v = wbits_i;
        if (lock_now)   clr_v = '1;
        if (raise_we_i) set_v = wbits_i;
        if (!lock_q)    set_v = set_v | rise_i;
        if (release_now) set_v = set_v | defer_q | rise_i;
        if (release_now)  defer_d = '0;
        else if (lock_q)  defer_d = defer_q | rise_i;
        else              defer_d = defer_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            mask_q  <= '1;
            defer_q <= '0;
            lock_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            pend_q  <= (pend_q & ~clr_v) | set_v;
            defer_q <= defer_d;
            irq_q   <= ~lock_q & (|(pend_q & ~mask_q));
            if (mask_we_i) mask_q <= wbits_i;
            if (lock_we_i) lock_q <= lock_bit_i;
        end
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign defer_o = defer_q;
    assign lock_o  = lock_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/irq_scratch.sv
module irq_scratch #(
    parameter int SLOTS = 7,
    parameter int DW    = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [SW-1:0] slot_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] word_o [SLOTS]
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)                          word_q <= '0;
            else if (we_i && slot_i == SW'(s)) word_q <= wdata_i;
        end
        assign word_o[s] = word_q;
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_LINES = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_LINES-1:0]  req_i,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    output logic                cpu_irq
);
    localparam logic [N_LINES-1:0] LIVE_LINES = {{(N_LINES-1){1'b1}}, 1'b0};

    bus_req_t           bus;
    bus_dec_t           dec;
    logic [WORD_AW-1:0] word;
    logic               aligned, wr_ok;
    logic [N_LINES-1:0] rise, pend, mask, defer;
    logic               lock;
    logic [BUS_DW-1:0]  scr_word [SCRATCH_SLOTS];

    assign bus = '{sel: bus_sel, wr: bus_wr, addr: bus_addr, wdata: bus_wdata};
    assign word    = bus.addr[BUS_AW-1:2];
    assign aligned = (bus.addr[1:0] == 2'b00);
    assign wr_ok   = bus.sel & bus.wr & aligned;

    always_comb begin
        dec             = '0;
        dec.mask_we     = wr_ok && (word == W_MASK);
        dec.clr_we      = wr_ok && (word == W_CLR);
        dec.raise_we    = wr_ok && (word == W_RAISE);
        dec.lock_we     = wr_ok && (word == W_LOCK);
        dec.scratch_hit = is_scratch(word);
        dec.scratch_we  = wr_ok && dec.scratch_hit;
        dec.slot        = slot_of(word);
    end

    irq_edge_det #(.N(N_LINES), .ACTIVE_MASK(LIVE_LINES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .rise_o (rise)
    );

    irq_pend_core #(.N(N_LINES)) u_core (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .mask_we_i  (dec.mask_we),
        .clr_we_i   (dec.clr_we),
        .raise_we_i (dec.raise_we),
        .lock_we_i  (dec.lock_we),
        .wbits_i    (bus.wdata[N_LINES-1:0]),
        .lock_bit_i (bus.wdata[0]),
        .pend_o     (pend),
        .mask_o     (mask),
        .defer_o    (defer),
        .lock_o     (lock),
        .irq_o      (cpu_irq)
    );

    irq_scratch #(.SLOTS(SCRATCH_SLOTS), .DW(BUS_DW)) u_scr (
        .clk     (clk),
        .rst     (rst),
        .we_i    (dec.scratch_we),
        .slot_i  (dec.slot),
        .wdata_i (bus.wdata),
        .word_o  (scr_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus.sel && !bus.wr && aligned) begin
            if (dec.scratch_hit) begin
                bus_rdata = scr_word[dec.slot];
            end else begin
                case (word)
                    W_MASK:  bus_rdata[N_LINES-1:0] = mask;
                    W_PEND:  bus_rdata[N_LINES-1:0] = pend;
                    W_LOCK:  bus_rdata[0]           = lock;
                    default: bus_rdata              = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int N = 6
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic [11:0]  bus_addr,
    input logic [31:0]  bus_wdata,
    input logic [31:0]  bus_rdata,
    input logic         cpu_irq,
    input logic [N-1:0] pend,
    input logic [N-1:0] mask,
    input logic [N-1:0] defer,
    input logic         lock,
    input logic [N-1:0] rise
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask == '1 && pend == '0 && defer == '0 && !lock && !cpu_irq));

    // R2
    line0_hw_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[0]) |-> $past(bus_sel && bus_wr && bus_addr == 12'h00C && bus_wdata[0]));

    // R3
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 12'h008 && bus_wdata[N-1:0] == '1 && rise == '0)
        |=> (pend == '0));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock && (pend & ~mask) == '0) |=> !cpu_irq);

    // R6
    lock_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> !cpu_irq);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && !(bus_sel && bus_wr)) |=> $stable(pend));

    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (bus_addr == 12'h008 || bus_addr == 12'h00C)) |-> (bus_rdata == '0));
endmodule

bind irq_hub irq_hub_chk #(.N(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .pend      (pend),
    .mask      (mask),
    .defer     (defer),
    .lock      (lock),
    .rise      (rise)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int N = 6;
    localparam logic [N-1:0] LIVE = {{(N-1){1'b1}}, 1'b0};

    logic         clk = 1'b0, rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         cpu_irq;

    always #10 clk = ~clk;

    irq_hub #(.N_LINES(N)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [N-1:0] m_pend, m_mask, m_defer, m_req_q;
    logic         m_lock, m_irq;
    logic [31:0]  m_word [12];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pend = '0; m_mask = '1; m_defer = '0; m_req_q = '0;
        m_lock = 1'b0; m_irq = 1'b0;
        for (int i = 0; i < 12; i++) m_word[i] = '0;
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [9:0]  w;
        logic [31:0] v;
        w = a[11:2];
        v = '0;
        if (a[1:0] != 2'b00) return '0;
        if (w == 10'd0)                      v[N-1:0] = m_mask;
        else if (w == 10'd1)                 v[N-1:0] = m_pend;
        else if (w == 10'd10)                v[0]     = m_lock;
        else if ((w >= 10'd4 && w <= 10'd9) || w == 10'd11) v = m_word[w];
        return v;
    endfunction

    task automatic model_step(input logic [N-1:0] r, input logic s, input logic w,
                              input logic [11:0] a, input logic [31:0] d);
        logic [N-1:0] rise_v, clr_v, set_v, defer_n;
        logic         we, rel, lk, irq_n;
        logic [9:0]   wd;
        rise_v = r & ~m_req_q & LIVE;
        we  = s && w && (a[1:0] == 2'b00);
        wd  = a[11:2];
        rel = we && wd == 10'd10 && !d[0] && m_lock;
        lk  = we && wd == 10'd10 && d[0];
        irq_n = !m_lock && (|(m_pend & ~m_mask));
        clr_v = (we && wd == 10'd2) ? d[N-1:0] : '0;
        if (lk) clr_v = '1;
        set_v = (we && wd == 10'd3) ? d[N-1:0] : '0;
        if (!m_lock) set_v |= rise_v;
        if (rel) set_v |= m_defer | rise_v;
        defer_n = rel ? '0 : (m_lock ? (m_defer | rise_v) : m_defer);
        m_pend  = (m_pend & ~clr_v) | set_v;
        m_defer = defer_n;
        m_irq   = irq_n;
        m_req_q = r;
        if (we && wd == 10'd0)  m_mask = d[N-1:0];
        if (we && wd == 10'd10) m_lock = d[0];
        if (we && ((wd >= 10'd4 && wd <= 10'd9) || wd == 10'd11)) m_word[wd] = d;
    endtask

    // one clock: drive at negedge, sample read before the edge, check irq after
    task automatic step(input logic [N-1:0] r, input logic s, input logic w,
                        input logic [11:0] a, input logic [31:0] d, output logic [31:0] rd);
        req = r; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk);
        model_step(r, s, w, a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R5 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_irq});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] unused_rd;
        step(req, 1'b1, 1'b1, a, d, unused_rd);
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        logic [31:0] e, got;
        e = exp_read(a);
        step(req, 1'b1, 1'b0, a, '0, got);
        chk(tag, got, e);
    endtask

    task automatic idle(input logic [N-1:0] r);
        logic [31:0] unused_rd;
        step(r, 1'b0, 1'b0, 12'h000, '0, unused_rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cpu_irq reset", {31'b0, cpu_irq}, 32'd0);
        rd("R1 mask reset", 12'h000);
        chk("R1 mask all ones", exp_read(12'h000), 32'h3F);
        rd("R1 pend reset", 12'h004);
        rd("R1 lock reset", 12'h028);
        rd("R1 word reset", 12'h010);
        rd("R1 index reset", 12'h02C);

        // R7 general words
        wr(12'h014, 32'hA5A5_1234);
        wr(12'h02C, 32'h0000_0005);
        wr(12'h020, 32'hDEAD_BEEF);
        rd("R7 table hi", 12'h014);
        rd("R7 index", 12'h02C);
        rd("R7 ret lo", 12'h020);
        rd("R7 cause lo", 12'h018);

        // R8 undefined / write-only / misaligned / reserved bits
        wr(12'h030, 32'hFFFF_FFFF);
        rd("R8 undefined read", 12'h030);
        chk("R8 undefined expect", exp_read(12'h030), 32'h0);
        wr(12'h016, 32'h1111_1111);
        rd("R8 misaligned write ignored", 12'h014);
        rd("R8 misaligned read", 12'h015);
        rd("R8 clear read", 12'h008);
        rd("R8 raise read", 12'h00C);
        wr(12'h000, 32'hFFFF_FFFF);
        rd("R8 mask reserved", 12'h000);

        // R2 line 0 is dead, line 1 edge
        idle(6'b000001); idle(6'b000000); idle(6'b000001);
        rd("R2 line0 ignored", 12'h004);
        idle(6'b000011);
        rd("R2 line1 edge", 12'h004);
        chk("R2 line1 pend value", exp_read(12'h004), 32'h2);
        wr(12'h000, 32'h3D);
        idle(req); idle(req);
        chk("R5 unmasked line1 irq", {31'b0, cpu_irq}, 32'd1);

        // R3 clear, no re-trigger while held high
        wr(12'h008, 32'h2);
        idle(req); idle(req);
        rd("R3 clear bit1", 12'h004);
        rd("R2 held high no reset", 12'h004);
        chk("R5 irq drops", {31'b0, cpu_irq}, 32'd0);

        // R4 raise, and set beats clear in the same cycle
        wr(12'h00C, 32'h15);
        rd("R4 raise bits", 12'h004);
        chk("R4 raise value", exp_read(12'h004), 32'h17 & 32'h15);
        begin
            logic [31:0] unused_rd;
            step(req | 6'b001000, 1'b1, 1'b1, 12'h008, 32'h3F, unused_rd);
        end
        rd("R4 set wins over clear", 12'h004);
        chk("R4 set wins value", exp_read(12'h004), 32'h8);

        // R6 lock: clears, blocks, defers, replays
        wr(12'h000, 32'h00);
        wr(12'h028, 32'h1);
        rd("R6 lock clears pend", 12'h004);
        rd("R6 lock reads 1", 12'h028);
        idle(req | 6'b010000);
        idle(req); idle(req);
        rd("R6 deferred not pending", 12'h004);
        chk("R6 irq blocked", {31'b0, cpu_irq}, 32'd0);
        wr(12'h00C, 32'h4);
        idle(req); idle(req);
        chk("R6 raise still blocked", {31'b0, cpu_irq}, 32'd0);
        begin
            logic [31:0] unused_rd;
            step(req | 6'b100000, 1'b1, 1'b1, 12'h028, 32'h0, unused_rd);
        end
        rd("R6 replay on release", 12'h004);
        chk("R6 replay value", exp_read(12'h004), 32'h34);
        idle(req);
        chk("R6 irq after release", {31'b0, cpu_irq}, 32'd1);

        // constrained random mix
        void'($urandom(32'd20240611));
        for (int it = 0; it < 4000; it++) begin
            logic [N-1:0] nr;
            logic [31:0]  d;
            int           op;
            nr = req ^ N'($urandom & ($urandom % 4 == 0 ? 32'h3F : 32'h0));
            op = int'($urandom % 10);
            d  = $urandom;
            req = nr;
            case (op)
                0: wr(12'h008, d);
                1: wr(12'h00C, d & 32'h3E);
                2: wr(12'h000, d);
                3: wr(12'h028, {31'b0, d[0] & d[1]});
                4: wr(12'h028, 32'h0);
                5: wr(12'h010 + 12'(4 * ($urandom % 6)), d);
                6: rd("R3 random pend", 12'h004);
                7: rd("R7 random word", 12'h010 + 12'(4 * ($urandom % 6)));
                8: rd("R8 random undefined", 12'h040 + 12'($urandom % 12'h7C0));
                default: idle(nr);
            endcase
        end
        rd("R6 final lock", 12'h028);
        rd("R5 final mask", 12'h000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule